// File: doc/BRIEF.md
# Decaying-Rate Tick Generator

This block stands in for a free-running oscillator whose rate collapses and then fades away. It produces a square wave and a one-cycle tick on each rising edge of that wave. While the run/stop level asks for run, the wave toggles at a fast nominal rate, 35 kHz by default. When the level changes to stop, the half period is reloaded at once with a much longer value, about 65 Hz by default. After that, every tick stretches the half period by a fixed binary fraction of itself. Ticking ends when the stop interval reaches its time budget (about 15 s by default) or when the half period grows past a ceiling. The block then raises a stopped flag and holds the square wave low.

The run/stop level comes from a mechanical switch, so the block synchronises it and debounces it before using it. All rates are given as parameters in hertz and are divided down from the system clock frequency. The same RTL therefore gives the nominal rates on any clock. A bench can also shrink every interval to a few thousand cycles.

Top module: `decay_tick_gen`

## Requirements
- R1: While rst_ni is low, tick_o, sq_o and stopped_o are 0, and the block starts in run mode.
- R2: In run mode, consecutive ticks are exactly 2*RUN_HALF cycles apart, where RUN_HALF = CLK_HZ/(2*RUN_HZ). sq_o is high for RUN_HALF cycles and low for RUN_HALF cycles.
- R3: tick_o is high for one cycle only. It is high in exactly the cycles in which sq_o has just gone from 0 to 1.
- R4: An accepted change from run to stop reloads the half period with STOP_HALF = CLK_HZ/(2*STOP_HZ) at once. The gap from the first tick in stop mode to the second tick is 2*(STOP_HALF + (STOP_HALF >> GROW_SHIFT)) cycles.
- R5: In stop mode, each tick replaces the half period h with h + (h >> GROW_SHIFT). The gap from that tick to the next tick is twice the new h.
- R6: When a tick raises the half period above MAX_HALF = STOP_HALF*MAX_RATIO, stopped_o goes to 1 in the cycle after that tick, and no further tick follows.
- R7: When the stop interval reaches STOP_CYC = (CLK_HZ/1000)*STOP_TIME_MS cycles, counted from the moment stop mode takes effect, stopped_o goes to 1 even if the half period is still below its ceiling.
- R8: While stopped_o is 1, sq_o and tick_o stay 0. stopped_o stays 1 for as long as stop mode holds.
- R9: run_i high selects run and run_i low selects stop. run_i passes through two synchroniser flops. A new level takes effect only after it has been held for DEB_CYC = (CLK_HZ/1000000)*DEBOUNCE_US consecutive cycles, so a shorter pulse does not change the tick pattern.
- R10: An accepted change from stop to run clears stopped_o in the next cycle and reloads the fast half period, so run-mode gaps of 2*RUN_HALF resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run/stop level from the switch (1 = run, 0 = stop), asynchronous |
| tick_o | output | 1 | One-cycle pulse on each rising edge of sq_o |
| sq_o | output | 1 | Square-wave output |
| stopped_o | output | 1 | High once ticking has ceased in stop mode |

## Verification
On every cycle, the assertions check the following. The tick is one cycle wide and lines up with the rising edge of the square wave. A halted block is silent and stays halted while stop mode holds. The flag clears right after a return to run. Steady run-mode ticks keep the fixed gap. The bench's scenarios cover the rest. They show the full geometric sequence of gaps after a stop, and the point where the period ceiling ends it. They show a second instance halting on its time budget, within the window expected for that budget. They also show that a switch glitch shorter than the debounce time leaves the run-mode gaps unchanged.

// File: rtl/decay_tick_pkg.sv
package decay_tick_pkg;

  // debounced mode level plus one-cycle change pulses
  typedef struct packed {
    logic run;
    logic to_run;
    logic to_stop;
  } mode_evt_t;

endpackage

// File: rtl/decay_tick_deb.sv
module decay_tick_deb
  import decay_tick_pkg::*;
#(
  parameter int unsigned DEB_CYC = 4,
  parameter int unsigned DEB_W   = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  output mode_evt_t evt_o
);

  logic             s1_q, s2_q, stable_q, to_run_q, to_stop_q;
  logic [DEB_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q      <= 1'b1;
      s2_q      <= 1'b1;
      stable_q  <= 1'b1;
      to_run_q  <= 1'b0;
      to_stop_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      s1_q      <= run_i;
      s2_q      <= s1_q;
      to_run_q  <= 1'b0;
      to_stop_q <= 1'b0;
      if (s2_q != stable_q) begin
        if (cnt_q == DEB_W'(DEB_CYC - 1)) begin
          stable_q  <= s2_q;
          cnt_q     <= '0;
          to_run_q  <= s2_q;
          to_stop_q <= ~s2_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign evt_o = '{run: stable_q, to_run: to_run_q, to_stop: to_stop_q};

endmodule

// File: rtl/decay_tick_ctrl.sv
module decay_tick_ctrl
  import decay_tick_pkg::*;
#(
  parameter int unsigned     RUN_HALF   = 4,
  parameter int unsigned     STOP_HALF  = 16,
  parameter int unsigned     MAX_HALF   = 128,
  parameter longint unsigned STOP_CYC   = 1000,
  parameter int unsigned     GROW_SHIFT = 4,
  parameter int unsigned     HALF_W     = 9,
  parameter int unsigned     ELAP_W     = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_evt_t         evt_i,
  input  logic              rise_i,
  output logic              load_o,
  output logic [HALF_W-1:0] load_half_o,
  output logic [HALF_W-1:0] rise_half_o,
  output logic [HALF_W-1:0] fall_half_o,
  output logic              halt_o,
  output logic              stopped_o
);

  logic [HALF_W-1:0] half_q, grow;
  logic [ELAP_W-1:0] elapsed_q;
  logic              stopped_q, halt_now;

  assign grow        = half_q + (half_q >> GROW_SHIFT);
  assign load_o      = evt_i.to_run | evt_i.to_stop;
  assign load_half_o = evt_i.run ? HALF_W'(RUN_HALF) : HALF_W'(STOP_HALF);
  assign rise_half_o = evt_i.run ? half_q : grow;
  assign fall_half_o = half_q;

  // either budget exhausted ends the decay
  assign halt_now = !evt_i.run && !load_o && !stopped_q &&
                    ((elapsed_q == ELAP_W'(STOP_CYC - 1)) || (half_q > HALF_W'(MAX_HALF)));
  assign halt_o    = stopped_q | halt_now;
  assign stopped_o = stopped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q    <= HALF_W'(RUN_HALF);
      elapsed_q <= '0;
      stopped_q <= 1'b0;
    end else if (load_o) begin
      half_q    <= load_half_o;
      elapsed_q <= '0;
      stopped_q <= 1'b0;
    end else if (evt_i.run) begin
      stopped_q <= 1'b0;
    end else if (!stopped_q) begin
      if (halt_now) begin
        stopped_q <= 1'b1;
      end else begin
        elapsed_q <= elapsed_q + 1'b1;
        if (rise_i) half_q <= grow;
      end
    end
  end

endmodule

// File: rtl/decay_tick_div.sv
module decay_tick_div #(
  parameter int unsigned RUN_HALF = 4,
  parameter int unsigned HALF_W   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [HALF_W-1:0] load_half_i,
  input  logic [HALF_W-1:0] rise_half_i,
  input  logic [HALF_W-1:0] fall_half_i,
  input  logic              halt_i,
  output logic              rise_o,
  output logic              sq_o,
  output logic              tick_o
);

  logic [HALF_W-1:0] cnt_q;
  logic              sq_q, tick_q, edge_now;

  assign edge_now = (cnt_q == '0);
  assign rise_o   = edge_now && !sq_q && !load_i && !halt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= HALF_W'(RUN_HALF - 1);
      sq_q   <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (load_i) begin
        cnt_q <= load_half_i - 1'b1;
      end else if (halt_i) begin
        sq_q  <= 1'b0;
        cnt_q <= '0;
      end else if (edge_now) begin
        sq_q <= ~sq_q;
        if (!sq_q) begin
          cnt_q  <= rise_half_i - 1'b1;
          tick_q <= 1'b1;
        end else begin
          cnt_q <= fall_half_i - 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign sq_o   = sq_q;
  assign tick_o = tick_q;

endmodule

// File: rtl/decay_tick_gen.sv
module decay_tick_gen
  import decay_tick_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 125_000_000,
  parameter int unsigned RUN_HZ       = 35_000,
  parameter int unsigned STOP_HZ      = 65,
  parameter int unsigned STOP_TIME_MS = 15_000,
  parameter int unsigned DEBOUNCE_US  = 10_000,
  parameter int unsigned GROW_SHIFT   = 4,
  parameter int unsigned MAX_RATIO    = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o,
  output logic sq_o,
  output logic stopped_o
);

  localparam int unsigned     RUN_HALF  = CLK_HZ / (2 * RUN_HZ);
  localparam int unsigned     STOP_HALF = CLK_HZ / (2 * STOP_HZ);
  localparam int unsigned     MAX_HALF  = STOP_HALF * MAX_RATIO;
  localparam longint unsigned STOP_CYC  = longint'(CLK_HZ / 1000) * STOP_TIME_MS;
  localparam int unsigned     DEB_RAW   = (CLK_HZ / 1_000_000) * DEBOUNCE_US;
  localparam int unsigned     DEB_CYC   = (DEB_RAW > 0) ? DEB_RAW : 1;
  localparam int unsigned     HALF_W    = $clog2(MAX_HALF + (MAX_HALF >> GROW_SHIFT) + 2) + 1;
  localparam int unsigned     ELAP_W    = $clog2(STOP_CYC + 1);
  localparam int unsigned     DEB_W     = $clog2(DEB_CYC + 1);

  mode_evt_t         mode_evt;
  logic              run_lvl, load, halt, rise;
  logic [HALF_W-1:0] load_half, rise_half, fall_half;

  assign run_lvl = mode_evt.run;

  decay_tick_deb #(.DEB_CYC(DEB_CYC), .DEB_W(DEB_W)) u_deb (
    .clk_i, .rst_ni, .run_i, .evt_o(mode_evt)
  );

  decay_tick_ctrl #(
    .RUN_HALF(RUN_HALF), .STOP_HALF(STOP_HALF), .MAX_HALF(MAX_HALF),
    .STOP_CYC(STOP_CYC), .GROW_SHIFT(GROW_SHIFT), .HALF_W(HALF_W), .ELAP_W(ELAP_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .evt_i(mode_evt), .rise_i(rise),
    .load_o(load), .load_half_o(load_half), .rise_half_o(rise_half),
    .fall_half_o(fall_half), .halt_o(halt), .stopped_o
  );

  decay_tick_div #(.RUN_HALF(RUN_HALF), .HALF_W(HALF_W)) u_div (
    .clk_i, .rst_ni, .load_i(load), .load_half_i(load_half),
    .rise_half_i(rise_half), .fall_half_i(fall_half), .halt_i(halt),
    .rise_o(rise), .sq_o, .tick_o
  );

endmodule

// File: rtl/decay_tick_gen_chk.sv
module decay_tick_gen_chk #(
  parameter int unsigned RUN_HALF = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic run_lvl,
  input logic tick_o,
  input logic sq_o,
  input logic stopped_o
);

  logic [31:0] gap_q;
  logic        clean_q;

  // gap since last tick; clean when the last tick came from steady run mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      clean_q <= 1'b0;
    end else begin
      gap_q <= tick_o ? '0 : gap_q + 1'b1;
      if (!run_lvl || $rose(run_lvl)) clean_q <= 1'b0;
      else if (tick_o)                clean_q <= 1'b1;
    end
  end

  a_r3_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  a_r3_tick_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $rose(sq_o));

  a_r3_rise_has_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sq_o) |-> tick_o);

  a_r8_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o |-> (!sq_o && !tick_o));

  a_r8_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped_o && !run_lvl) |=> stopped_o);

  a_r10_clear_on_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_lvl) |=> !stopped_o);

  a_r2_run_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && clean_q && run_lvl) |-> (gap_q == 32'(2 * RUN_HALF - 1)));

endmodule

bind decay_tick_gen decay_tick_gen_chk #(.RUN_HALF(RUN_HALF)) u_chk (
  .clk_i, .rst_ni, .run_lvl, .tick_o, .sq_o, .stopped_o
);

// File: tb/decay_tick_gen_bench.sv
module decay_tick_gen_bench;

  localparam int CLK_HZ  = 1_000_000;
  localparam int RUN_GAP = 20;     // 2*RUN_HALF, RUN_HZ=50k
  localparam int H0      = 100;    // STOP_HALF, STOP_HZ=5k
  localparam int SHIFT   = 4;
  localparam int MAXH    = 800;    // H0*8
  localparam int DEB     = 50;     // 50 us
  localparam int TL_CYC  = 5000;   // 5 ms budget of second instance

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic run_i = 1'b1;
  logic tick_a, sq_a, stop_a, tick_b, sq_b, stop_b;

  always #4 clk = ~clk;

  decay_tick_gen #(
    .CLK_HZ(CLK_HZ), .RUN_HZ(50_000), .STOP_HZ(5_000), .STOP_TIME_MS(100),
    .DEBOUNCE_US(DEB), .GROW_SHIFT(SHIFT), .MAX_RATIO(8)
  ) u_decay_tick_gen (
    .clk_i(clk), .rst_ni, .run_i, .tick_o(tick_a), .sq_o(sq_a), .stopped_o(stop_a)
  );

  decay_tick_gen #(
    .CLK_HZ(CLK_HZ), .RUN_HZ(50_000), .STOP_HZ(5_000), .STOP_TIME_MS(5),
    .DEBOUNCE_US(DEB), .GROW_SHIFT(SHIFT), .MAX_RATIO(8)
  ) u_decay_tick_gen_tl (
    .clk_i(clk), .rst_ni, .run_i, .tick_o(tick_b), .sq_o(sq_b), .stopped_o(stop_b)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    exp_q[$];
  string req_q[$];
  int    last_tick = 0;
  int    tick_total = 0;
  int    stop_fall_cyc = 0;
  bit    prev_sq = 1'b0, prev_tick = 1'b0, prev_stop_a = 1'b0, prev_stop_b = 1'b0;
  bit    tl_seen = 1'b0;
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int gap, input string req);
    exp_q.push_back(gap);
    req_q.push_back(req);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected gaps as ticks appear
  always @(negedge clk) begin
    if (rst_ni) begin
      if (tick_a) begin
        chk(sq_a && !prev_sq && !prev_tick, "R3", "tick aligned single", {sq_a, prev_sq, prev_tick}, 3'b100);
        if (exp_q.size() > 0) begin
          int    e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          if (e != 0) chk(cyc - last_tick == e, r, "tick gap", cyc - last_tick, e);
        end
        last_tick = cyc;
        tick_total++;
      end
      if (stop_a && !prev_stop_a)
        chk(cyc - last_tick == 1, "R6", "halt one cycle after last tick", cyc - last_tick, 1);
      if (stop_b && !prev_stop_b && !run_i) begin
        tl_seen = 1'b1;
        chk((cyc - stop_fall_cyc >= TL_CYC + DEB) && (cyc - stop_fall_cyc <= TL_CYC + DEB + 6),
            "R7", "time budget halt", cyc - stop_fall_cyc, TL_CYC + DEB + 3);
        chk(!sq_b, "R8", "sq low at time halt", sq_b, 0);
      end
      prev_sq     = sq_a;
      prev_tick   = tick_a;
      prev_stop_a = stop_a;
      prev_stop_b = stop_b;
    end
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n0;
    int h;
    wait_cyc(5);
    chk(!tick_a && !sq_a && !stop_a, "R1", "outputs in reset", {tick_a, sq_a, stop_a}, 0);
    chk(!tick_b && !sq_b && !stop_b, "R1", "second instance in reset", {tick_b, sq_b, stop_b}, 0);
    rst_ni = 1'b1;

    // R2: steady run gaps
    push(0, "R2");
    for (int i = 0; i < 8; i++) push(RUN_GAP, "R2");
    wait_cyc(9 * RUN_GAP + 20);
    chk(exp_q.size() == 0, "R2", "run ticks consumed", exp_q.size(), 0);

    // R9: glitch shorter than debounce ignored
    push(0, "R9");
    for (int i = 0; i < 10; i++) push(RUN_GAP, "R9");
    run_i = 1'b0;
    wait_cyc(30);
    run_i = 1'b1;
    wait_cyc(11 * RUN_GAP);
    chk(exp_q.size() == 0, "R9", "glitch gaps consumed", exp_q.size(), 0);
    chk(!stop_a, "R9", "no halt after glitch", stop_a, 0);

    // R4/R5/R6: stop and decay to the period ceiling
    run_i = 1'b0;
    stop_fall_cyc = cyc;
    wait_cyc(DEB + 5);
    push(0, "R4");
    h = H0;
    for (int i = 0; i < 200; i++) begin
      h = h + (h >> SHIFT);
      if (h > MAXH) break;
      push(2 * h, (i == 0) ? "R4" : "R5");
    end
    for (int i = 0; i < 60_000 && !stop_a; i++) @(negedge clk);
    chk(stop_a, "R6", "halted on period ceiling", stop_a, 1);
    chk(exp_q.size() == 0, "R5", "all decay gaps seen", exp_q.size(), 0);
    chk(tl_seen, "R7", "second instance halted on time", tl_seen, 1);

    // R8: silent and held while stop mode lasts
    n0 = tick_total;
    wait_cyc(1500);
    chk(tick_total == n0, "R8", "no ticks while halted", tick_total - n0, 0);
    chk(stop_a && !sq_a, "R8", "halt held with sq low", {stop_a, sq_a}, 2'b10);
    chk(stop_b && !sq_b, "R8", "second halt held", {stop_b, sq_b}, 2'b10);

    // R10: back to run
    run_i = 1'b1;
    n0 = cyc;
    for (int i = 0; i < 200 && stop_a; i++) @(negedge clk);
    chk(!stop_a && (cyc - n0 <= DEB + 6), "R10", "stopped clears after run", cyc - n0, DEB + 4);
    push(0, "R10");
    for (int i = 0; i < 5; i++) push(RUN_GAP, "R10");
    wait_cyc(7 * RUN_GAP);
    chk(exp_q.size() == 0, "R10", "fast gaps resumed", exp_q.size(), 0);
    chk(!stop_b, "R10", "second instance cleared", stop_b, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule